// File: doc/BRIEF.md
# Audio Sample FIFO Controller

This block sits between a register-style host port and the serializer of a two-direction serial audio port. It keeps one sample queue for playback and one for capture, each 32 entries deep by default. The host pushes 32-bit playback samples by writing a data address and pops capture samples by reading another. The serializer drains the playback queue and fills the capture queue through ready/valid handshakes.

A status word reports how full each queue is. Two request flags tell the host when to move more data. The playback request depends on a programmable low-water mark. The capture request depends on a programmable high-water mark. Four sticky error flags record underflow and overflow in each direction. Each request or error flag can raise an interrupt through its own enable.

After any error the host stops the stream and empties both queues before it restarts. For that it has two hold-empty controls, one per queue, and a soft reset that returns the whole block to its power-up state.

Top module: `audio_fifo_ctl`

## Requirements
- R1: After reset the control word (address 0) reads zero, both occupancy fields read zero, all four error flags are clear and no interrupt output is high.
- R2: Words written to address 2 leave on ser_tx_data in write order, one per cycle where ser_tx_valid and ser_tx_ready are both high. The playback occupancy appears in status (address 1) bits 29:24.
- R3: Samples accepted on the capture handshake are returned in arrival order by reads of address 3. The capture occupancy appears in status bits 13:8.
- R4: Status bit 16 (playback request) sets when playback occupancy is at or below the threshold in control bits 20:16. irq_tx_req is that flag ANDed with control bit 2.
- R5: Status bit 0 (capture request) sets when capture occupancy is above the threshold in control bits 28:24, so a threshold of 0 requests on any sample. irq_rx_req is that flag ANDed with control bit 3.
- R6: A write to address 1 clears exactly the flag bits (0, 1 to 4, 16) written as zero. Flag bits written as one and the occupancy fields are left unchanged. A flag whose request condition still holds sets again.
- R7: A write to address 2 while the playback queue holds 32 entries is dropped and sets status bit 2 (playback overflow).
- R8: A read of address 3 while the capture queue is empty returns zero and sets status bit 3 (capture underflow).
- R9: A pulse on ser_tx_udf sets status bit 1 and a pulse on ser_rx_ovf sets status bit 4. ser_rx_ready is low while the capture queue holds 32 entries.
- R10: irq_err is high exactly when some error flag in status bits 4:1 is set together with its enable in control bits 7:4, taken in the same order.
- R11: Control bit 0 holds the playback queue empty and drops host writes without flagging overflow. Control bit 1 holds the capture queue empty and keeps ser_rx_ready low.
- R12: Writing control with bit 8 set returns the control word, both queues and every flag to their reset state. Bit 8 itself is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 playback data, 3 capture data |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the access |
| ser_tx_valid | output | 1 | Playback sample available |
| ser_tx_ready | input | 1 | Serializer takes the playback sample |
| ser_tx_data | output | 32 | Playback sample at the queue head |
| ser_rx_valid | input | 1 | Serializer offers a capture sample |
| ser_rx_ready | output | 1 | Capture queue can take a sample |
| ser_rx_data | input | 32 | Capture sample |
| ser_tx_udf | input | 1 | Serializer playback underflow pulse |
| ser_rx_ovf | input | 1 | Serializer capture overflow pulse |
| irq_tx_req | output | 1 | Enabled playback request |
| irq_rx_req | output | 1 | Enabled capture request |
| irq_err | output | 1 | Enabled error summary |

## Verification
Read data and ser_tx_data follow their inputs in the same cycle. Occupancy, control and error flags change at the first clock edge after the access or pulse. The request flags compare the registered occupancy, so they follow one edge later than the count. The bench changes inputs on the falling edge, samples one nanosecond later, and waits one extra cycle before looking at a request flag or request interrupt.

// File: rtl/afc_pkg.sv
package afc_pkg;
    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_STAT = 2'd1,
        ADDR_TXD  = 2'd2,
        ADDR_RXD  = 2'd3
    } afc_addr_e;

    // control word layout
    localparam int CTL_TXRST     = 0;
    localparam int CTL_RXRST     = 1;
    localparam int CTL_TXIE      = 2;
    localparam int CTL_RXIE      = 3;
    localparam int CTL_ERRIE_LSB = 4;
    localparam int CTL_SOFT      = 8;
    localparam int CTL_TXTHR_LSB = 16;
    localparam int CTL_RXTHR_LSB = 24;

    // status word layout
    localparam int ST_RXREQ     = 0;
    localparam int ST_ERR_LSB   = 1;
    localparam int ST_RXCNT_LSB = 8;
    localparam int ST_TXREQ     = 16;
    localparam int ST_TXCNT_LSB = 24;
    localparam int ST_CNT_W     = 6;

    // error flag order, shared by status and enable fields
    localparam int NERR      = 4;
    localparam int ERR_TXUDF = 0;
    localparam int ERR_TXOVF = 1;
    localparam int ERR_RXUDF = 2;
    localparam int ERR_RXOVF = 3;

    // sticky flag vector order
    localparam int FL_TXREQ   = 0;
    localparam int FL_RXREQ   = 1;
    localparam int FL_ERR_LSB = 2;
    localparam int NFLAG      = 2 + NERR;
endpackage

// File: rtl/afc_fifo.sv
module afc_fifo #(
    parameter int DEPTH = 32,
    parameter int DW    = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [DW-1:0]                wdata,
    input  logic                         pop,
    output logic [DW-1:0]                rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0]    rd;
        logic [AW-1:0]    wr;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [DW-1:0] mem [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        do_push = push && !full;
        do_pop  = pop && !empty;
        st_d    = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wr = (st_q.wr == AW'(DEPTH - 1)) ? '0 : st_q.wr + AW'(1);
            if (do_pop)  st_d.rd = (st_q.rd == AW'(DEPTH - 1)) ? '0 : st_q.rd + AW'(1);
            st_d.cnt = st_q.cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[st_q.wr] <= wdata;
    end

    assign rdata = mem[st_q.rd];
    assign count = st_q.cnt;
    assign full  = (st_q.cnt == CNT_W'(DEPTH));
    assign empty = (st_q.cnt == '0);
endmodule

// File: rtl/afc_sticky.sv
module afc_sticky #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_all,
    input  logic [N-1:0] set,
    input  logic         wr_en,
    input  logic [N-1:0] keep,
    output logic [N-1:0] flags
);
    logic [N-1:0] flags_d, flags_q;

    always_comb begin
        if (clr_all) flags_d = '0;
        else         flags_d = (flags_q & (wr_en ? keep : {N{1'b1}})) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;
endmodule

// File: rtl/audio_fifo_ctl.sv
module audio_fifo_ctl #(
    parameter int DEPTH = 32,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          ser_tx_valid,
    input  logic          ser_tx_ready,
    output logic [DW-1:0] ser_tx_data,
    input  logic          ser_rx_valid,
    output logic          ser_rx_ready,
    input  logic [DW-1:0] ser_rx_data,
    input  logic          ser_tx_udf,
    input  logic          ser_rx_ovf,
    output logic          irq_tx_req,
    output logic          irq_rx_req,
    output logic          irq_err
);
    import afc_pkg::*;

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int TW    = $clog2(DEPTH);

    typedef struct packed {
        logic [TW-1:0]   rx_thr;
        logic [TW-1:0]   tx_thr;
        logic [NERR-1:0] err_ie;
        logic            rx_ie;
        logic            tx_ie;
        logic            rx_rst;
        logic            tx_rst;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    afc_addr_e addr;
    logic ctrl_wr, stat_wr, txd_wr, rxd_rd, soft_rst, tx_hold;
    logic [CNT_W-1:0] tx_cnt, rx_cnt;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic [DW-1:0] rx_dout;
    logic [NFLAG-1:0] flag_set, flag_keep, flag_vec;
    logic [31:0] ctrl_img, stat_img;

    assign addr     = afc_addr_e'(reg_addr);
    assign ctrl_wr  = reg_wr && (addr == ADDR_CTRL);
    assign stat_wr  = reg_wr && (addr == ADDR_STAT);
    assign txd_wr   = reg_wr && (addr == ADDR_TXD);
    assign rxd_rd   = reg_rd && (addr == ADDR_RXD);
    assign soft_rst = ctrl_wr && reg_wdata[CTL_SOFT];
    assign tx_hold  = ctrl_q.tx_rst;

    always_comb begin
        ctrl_d = ctrl_q;
        if (soft_rst) begin
            ctrl_d = '0;
        end else if (ctrl_wr) begin
            ctrl_d.tx_rst = reg_wdata[CTL_TXRST];
            ctrl_d.rx_rst = reg_wdata[CTL_RXRST];
            ctrl_d.tx_ie  = reg_wdata[CTL_TXIE];
            ctrl_d.rx_ie  = reg_wdata[CTL_RXIE];
            ctrl_d.err_ie = reg_wdata[CTL_ERRIE_LSB +: NERR];
            ctrl_d.tx_thr = reg_wdata[CTL_TXTHR_LSB +: TW];
            ctrl_d.rx_thr = reg_wdata[CTL_RXTHR_LSB +: TW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    afc_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (soft_rst || ctrl_q.tx_rst),
        .push  (txd_wr && !ctrl_q.tx_rst),
        .wdata (DW'(reg_wdata)),
        .pop   (ser_tx_valid && ser_tx_ready),
        .rdata (ser_tx_data),
        .count (tx_cnt),
        .full  (tx_full),
        .empty (tx_empty)
    );

    assign ser_tx_valid = !tx_empty;
    assign ser_rx_ready = !rx_full && !ctrl_q.rx_rst;

    afc_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (soft_rst || ctrl_q.rx_rst),
        .push  (ser_rx_valid && ser_rx_ready),
        .wdata (ser_rx_data),
        .pop   (rxd_rd),
        .rdata (rx_dout),
        .count (rx_cnt),
        .full  (rx_full),
        .empty (rx_empty)
    );

    always_comb begin
        flag_set = '0;
        flag_set[FL_TXREQ] = tx_cnt <= CNT_W'(ctrl_q.tx_thr);
        flag_set[FL_RXREQ] = rx_cnt >  CNT_W'(ctrl_q.rx_thr);
        flag_set[FL_ERR_LSB + ERR_TXUDF] = ser_tx_udf;
        flag_set[FL_ERR_LSB + ERR_TXOVF] = txd_wr && tx_full;
        flag_set[FL_ERR_LSB + ERR_RXUDF] = rxd_rd && rx_empty;
        flag_set[FL_ERR_LSB + ERR_RXOVF] = ser_rx_ovf;
        flag_keep = '0;
        flag_keep[FL_TXREQ] = reg_wdata[ST_TXREQ];
        flag_keep[FL_RXREQ] = reg_wdata[ST_RXREQ];
        flag_keep[FL_ERR_LSB +: NERR] = reg_wdata[ST_ERR_LSB +: NERR];
    end

    afc_sticky #(.N(NFLAG)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (soft_rst),
        .set     (flag_set),
        .wr_en   (stat_wr),
        .keep    (flag_keep),
        .flags   (flag_vec)
    );

    assign irq_tx_req = flag_vec[FL_TXREQ] && ctrl_q.tx_ie;
    assign irq_rx_req = flag_vec[FL_RXREQ] && ctrl_q.rx_ie;
    assign irq_err    = |(flag_vec[FL_ERR_LSB +: NERR] & ctrl_q.err_ie);

    always_comb begin
        ctrl_img = '0;
        ctrl_img[CTL_TXRST] = ctrl_q.tx_rst;
        ctrl_img[CTL_RXRST] = ctrl_q.rx_rst;
        ctrl_img[CTL_TXIE]  = ctrl_q.tx_ie;
        ctrl_img[CTL_RXIE]  = ctrl_q.rx_ie;
        ctrl_img[CTL_ERRIE_LSB +: NERR] = ctrl_q.err_ie;
        ctrl_img[CTL_TXTHR_LSB +: TW]   = ctrl_q.tx_thr;
        ctrl_img[CTL_RXTHR_LSB +: TW]   = ctrl_q.rx_thr;
        stat_img = '0;
        stat_img[ST_TXREQ] = flag_vec[FL_TXREQ];
        stat_img[ST_RXREQ] = flag_vec[FL_RXREQ];
        stat_img[ST_ERR_LSB +: NERR]     = flag_vec[FL_ERR_LSB +: NERR];
        stat_img[ST_TXCNT_LSB +: ST_CNT_W] = ST_CNT_W'(tx_cnt);
        stat_img[ST_RXCNT_LSB +: ST_CNT_W] = ST_CNT_W'(rx_cnt);
        case (addr)
            ADDR_CTRL: reg_rdata = ctrl_img;
            ADDR_STAT: reg_rdata = stat_img;
            ADDR_RXD:  reg_rdata = rx_empty ? '0 : 32'(rx_dout);
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/afc_chk.sv
module afc_chk #(
    parameter int DEPTH = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       reg_wr,
    input logic                       reg_rd,
    input logic [1:0]                 reg_addr,
    input logic [31:0]                reg_rdata,
    input logic [$clog2(DEPTH+1)-1:0] tx_cnt,
    input logic [$clog2(DEPTH+1)-1:0] rx_cnt,
    input logic                       tx_hold,
    input logic                       soft_rst,
    input logic [5:0]                 flag_vec,
    input logic                       ser_rx_ready
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cnt <= CNT_W'(DEPTH) && rx_cnt <= CNT_W'(DEPTH));

    // R7
    tx_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd2 && tx_cnt == CNT_W'(DEPTH)) |=> flag_vec[3]);

    // R8
    rx_udf_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd3 && rx_cnt == '0) |-> reg_rdata == 32'd0);

    // R9
    rx_full_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt == CNT_W'(DEPTH)) |-> !ser_rx_ready);

    // R11
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_hold |=> tx_cnt == '0);

    // R12
    soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (tx_cnt == '0 && rx_cnt == '0 && flag_vec == 6'd0));
endmodule

bind audio_fifo_ctl afc_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .reg_addr     (reg_addr),
    .reg_rdata    (reg_rdata),
    .tx_cnt       (tx_cnt),
    .rx_cnt       (rx_cnt),
    .tx_hold      (tx_hold),
    .soft_rst     (soft_rst),
    .flag_vec     (flag_vec),
    .ser_rx_ready (ser_rx_ready)
);

// File: tb/sim_audio_fifo_ctl.sv
module sim_audio_fifo_ctl;
    localparam int DEPTH = 32;
    localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_TXD = 2'd2, A_RXD = 2'd3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, reg_wr, reg_rd, ser_tx_ready, ser_rx_valid, ser_tx_udf, ser_rx_ovf;
    logic [1:0] reg_addr;
    logic [31:0] reg_wdata, reg_rdata, ser_tx_data, ser_rx_data;
    logic ser_tx_valid, ser_rx_ready, irq_tx_req, irq_rx_req, irq_err;

    audio_fifo_ctl #(.DEPTH(DEPTH), .DW(32)) u0 (.*);

    int checks = 0, errors = 0;
    bit done = 0;
    logic [31:0] v, d;
    logic [31:0] txq[$];
    logic [31:0] rxq[$];

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] tx_cnt_of(logic [31:0] s); return {26'd0, s[29:24]}; endfunction
    function automatic logic [31:0] rx_cnt_of(logic [31:0] s); return {26'd0, s[13:8]};  endfunction

    task automatic step(int n); repeat (n) @(negedge clk); endtask

    task automatic wr(logic [1:0] a, logic [31:0] w);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = w;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] r);
        reg_rd = 1'b1; reg_addr = a;
        #1 r = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic tx_put(logic [31:0] w);
        wr(A_TXD, w);
        if (txq.size() < DEPTH) txq.push_back(w);
    endtask

    task automatic rx_put(logic [31:0] w);
        ser_rx_valid = 1'b1; ser_rx_data = w;
        #1 if (ser_rx_ready && rxq.size() < DEPTH) rxq.push_back(w);
        @(negedge clk);
        ser_rx_valid = 1'b0;
    endtask

    task automatic tx_drain(int n);
        ser_tx_ready = 1'b1;
        for (int i = 0; i < n; i++) begin
            #1;
            check("R2 tx valid", {31'd0, ser_tx_valid}, 32'd1);
            check("R2 tx order", ser_tx_data, txq.pop_front());
            @(negedge clk);
        end
        ser_tx_ready = 1'b0;
    endtask

    task automatic rx_drain();
        while (rxq.size() > 0) begin
            rd(A_RXD, v);
            check("R3 rx order", v, rxq.pop_front());
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
        ser_tx_ready = 0; ser_rx_valid = 0; ser_rx_data = 0; ser_tx_udf = 0; ser_rx_ovf = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        rd(A_CTRL, v); check("R1 ctrl", v, 32'd0);
        rd(A_STAT, v); check("R1 counts and errors", v & 32'h3F00_3F1E, 32'd0);
        check("R1 irqs", {29'd0, irq_tx_req, irq_rx_req, irq_err}, 32'd0);
        check("R4 request when empty", {31'd0, v[16]}, 32'd1);

        // R2, R6, R4 with threshold 0
        for (int i = 0; i < 3; i++) tx_put($urandom);
        rd(A_STAT, v); check("R2 tx count", tx_cnt_of(v), 32'd3);
        wr(A_STAT, 32'd0); step(1);
        rd(A_STAT, v); check("R6 tx request cleared", {31'd0, v[16]}, 32'd0);
        wr(A_CTRL, 32'h0000_0004);
        check("R4 irq idle above threshold", {31'd0, irq_tx_req}, 32'd0);
        tx_drain(3);
        #1 check("R2 tx empty", {31'd0, ser_tx_valid}, 32'd0);
        step(1);
        check("R4 irq when empty", {31'd0, irq_tx_req}, 32'd1);

        // R4 threshold 4
        wr(A_CTRL, (32'd4 << 16) | 32'h4);
        for (int i = 0; i < 5; i++) tx_put($urandom);
        wr(A_STAT, 32'd0); step(1);
        check("R4 above threshold", {31'd0, irq_tx_req}, 32'd0);
        tx_drain(1); step(1);
        check("R4 at threshold", {31'd0, irq_tx_req}, 32'd1);
        tx_drain(4);

        // R5 threshold 0, R3
        wr(A_CTRL, 32'h8);
        wr(A_STAT, 32'd0); step(1);
        check("R5 idle", {31'd0, irq_rx_req}, 32'd0);
        rx_put(32'hA5A5_0001); step(1);
        check("R5 one sample", {31'd0, irq_rx_req}, 32'd1);
        rd(A_STAT, v); check("R3 rx count", rx_cnt_of(v), 32'd1);
        rx_drain();
        rd(A_STAT, v); check("R3 rx count after read", rx_cnt_of(v), 32'd0);

        // R5 threshold 2
        wr(A_CTRL, (32'd2 << 24) | 32'h8);
        rx_put(32'h1111_0000); rx_put(32'h2222_0000);
        wr(A_STAT, 32'd0); step(1);
        check("R5 at threshold", {31'd0, irq_rx_req}, 32'd0);
        rx_put(32'h3333_0000); step(1);
        check("R5 above threshold", {31'd0, irq_rx_req}, 32'd1);
        rx_drain();

        // R8 underflow
        rd(A_RXD, v); check("R8 empty read data", v, 32'd0);
        rd(A_STAT, v); check("R8 underflow flag", {31'd0, v[3]}, 32'd1);

        // R7 overflow
        wr(A_CTRL, 32'd0);
        for (int i = 0; i < DEPTH + 1; i++) tx_put($urandom);
        rd(A_STAT, v);
        check("R7 tx count full", tx_cnt_of(v), 32'd32);
        check("R7 overflow flag", {31'd0, v[2]}, 32'd1);

        // R10 enables
        wr(A_CTRL, 32'h80);
        check("R10 unmatched enable", {31'd0, irq_err}, 32'd0);
        wr(A_CTRL, 32'h20);
        check("R10 matched enable", {31'd0, irq_err}, 32'd1);
        tx_drain(DEPTH);

        // R9 serializer pulses
        ser_tx_udf = 1; @(negedge clk); ser_tx_udf = 0;
        ser_rx_ovf = 1; @(negedge clk); ser_rx_ovf = 0;
        rd(A_STAT, v); check("R9 error flags", {28'd0, v[4:1]}, 32'hF);

        // R6 selective clear
        wr(A_STAT, ~32'h4);
        rd(A_STAT, v);
        check("R6 selective clear", {28'd0, v[4:1]}, 32'hD);
        check("R6 counts untouched", v & 32'h3F00_3F00, 32'd0);

        // R9 capture full
        for (int i = 0; i < DEPTH; i++) rx_put($urandom);
        #1 check("R9 rx ready when full", {31'd0, ser_rx_ready}, 32'd0);
        rx_put(32'hDEAD_BEEF);
        rd(A_STAT, v); check("R9 rx count full", rx_cnt_of(v), 32'd32);

        // R11 hold controls
        for (int i = 0; i < 3; i++) wr(A_TXD, $urandom);
        wr(A_CTRL, 32'h1); step(1);
        rd(A_STAT, v); check("R11 tx held empty", tx_cnt_of(v), 32'd0);
        wr(A_TXD, 32'h1234_5678);
        rd(A_STAT, v);
        check("R11 write dropped", tx_cnt_of(v), 32'd0);
        check("R11 no overflow", {31'd0, v[2]}, 32'd0);
        wr(A_CTRL, 32'h2); step(1);
        rxq.delete();
        rd(A_STAT, v); check("R11 rx held empty", rx_cnt_of(v), 32'd0);
        #1 check("R11 rx ready low", {31'd0, ser_rx_ready}, 32'd0);
        wr(A_CTRL, 32'h0);
        #1 check("R11 rx ready released", {31'd0, ser_rx_ready}, 32'd1);

        // R12 soft reset
        wr(A_TXD, 32'h5); wr(A_TXD, 32'h6); rx_put(32'h7);
        ser_tx_udf = 1; @(negedge clk); ser_tx_udf = 0;
        wr(A_CTRL, 32'h0301_01F0);
        rd(A_CTRL, v); check("R12 ctrl cleared", v, 32'd0);
        rd(A_STAT, v); check("R12 state cleared", v & 32'h3F00_3F1F, 32'd0);
        check("R12 irqs low", {29'd0, irq_tx_req, irq_rx_req, irq_err}, 32'd0);
        rxq.delete(); txq.delete();

        // random traffic against queue model
        for (int it = 0; it < 20; it++) begin
            int n, m;
            bit ovf;
            wr(A_STAT, 32'd0);
            n = $urandom_range(0, 36);
            ovf = (n > DEPTH);
            for (int i = 0; i < n; i++) tx_put($urandom);
            m = $urandom_range(0, 6);
            for (int i = 0; i < m; i++) rx_put($urandom);
            rd(A_STAT, v);
            check("R2 random tx count", tx_cnt_of(v), (n > DEPTH) ? 32'd32 : 32'(n));
            check("R3 random rx count", rx_cnt_of(v), 32'(m));
            check("R7 random overflow", {31'd0, v[2]}, {31'd0, ovf});
            tx_drain(txq.size());
            rx_drain();
        end

        finish_run();
    end
endmodule